// File: doc/BRIEF.md
# Digital Potentiometer Wiper and Data Register Controller

This block holds the register state behind a bank of digitally controlled potentiometers. Each channel owns one volatile wiper register, whose value drives an external tap decoder, and a small set of data registers that model non-volatile storage. A command decoder (outside this block) presents one already-decoded command per cycle. The command can read or write a wiper, read or write a data register, move a value between a data register and its wiper, step a wiper by one position, or read the write-busy status.

Data register changes model a slow non-volatile program cycle. A busy flag is held for a parameterised number of clocks. While it is set, further data register changes are refused. An active-low protect pin also blocks every data register change, but leaves wiper operations alone. Data registers keep their contents across `rst_ni`. Wiper registers do not. In the first clock after reset is released, every wiper is loaded from data register 0 of its channel.

Top module: `pot_reg_ctrl`

## Requirements
- R1: While `rst_ni` is low, `wip_o` and `rd_valid_o` are 0. In the first clock edge after release, each channel's wiper is loaded from its data register 0, and any command presented in that cycle is ignored.
- R2: Write-wiper (`cmd_op_i`=4'hA) loads `cmd_data_i` into the wiper of channel `cmd_ch_i`. The new value appears on `wcr_o[8*ch+7:8*ch]` after the edge. 8'h00 means the tap nearest the low end and 8'hFF the tap nearest the high end.
- R3: Write-data (4'hC) stores `cmd_data_i` into the data register chosen by `cmd_dr_i` (00→DR0, 01→DR1, 10→DR2, 11→DR3) of channel `cmd_ch_i`.
- R4: Load-wiper (4'hD) copies the selected data register into the channel's wiper.
- R5: Store-wiper (4'hE) copies the channel's wiper into the selected data register.
- R6: Step (4'h2) adds one to the wiper when `cmd_data_i[0]`=1 and subtracts one otherwise. It holds at 8'hFF going up and at 8'h00 going down.
- R7: Read-wiper (4'h9), read-data (4'hB) and read-status (4'h5) raise `rd_valid_o` for the one cycle after the command edge, with the value on `rd_data_o`. The status value is {7'b0, busy flag as seen at the command edge}.
- R8: An accepted write-data or store-wiper command sets `wip_o` to 1 for exactly `WRITE_CYCLES` cycles, starting right after the command edge.
- R9: While `wp_ni` is 0, write-data and store-wiper change no register and do not set `wip_o`. Wiper commands still take effect.
- R10: A write-data or store-wiper command that arrives while `wip_o` is 1 changes no register and does not extend the busy time.
- R11: Data register contents survive assertion of `rst_ni`.
- R12: Opcodes other than those listed above change no register and produce no read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_ni | input | 1 | Protect pin, active low; blocks data register changes |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 4 | Command opcode |
| cmd_ch_i | input | 2 | Channel select |
| cmd_dr_i | input | 2 | Data register select |
| cmd_data_i | input | 8 | Write data; bit 0 gives the step direction |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | 8 | Read response data |
| wip_o | output | 1 | Non-volatile write in progress |
| wcr_o | output | 32 | Wiper values, channel c at bits [8c+7:8c] |

## Verification
All sixteen data registers are first filled with distinct values. They are then read back, and a reset shows that each channel boots from its own DR0 and not from a neighbour or another slot. Steps are applied at both saturation ends so that a wrap and a missing clamp look different from a correct move. Data register changes are tried in three settings: while busy, with the protect pin low, and right after busy ends. This separates rejection from acceptance. A command placed in the boot cycle, and unused opcodes, must leave every output matching the model.

// File: rtl/pot_ctrl_pkg.sv
package pot_ctrl_pkg;
  typedef enum logic [3:0] {
    OP_STEP    = 4'h2,
    OP_RD_STAT = 4'h5,
    OP_RD_WCR  = 4'h9,
    OP_WR_WCR  = 4'hA,
    OP_RD_DR   = 4'hB,
    OP_WR_DR   = 4'hC,
    OP_DR2WCR  = 4'hD,
    OP_WCR2DR  = 4'hE
  } pot_op_e;
endpackage

// File: rtl/nv_busy_timer.sv
module nv_busy_timer #(
  parameter int CYCLES = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

  assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  assert_busy_countdown_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/wiper_chan.sv
module wiper_chan #(
  parameter int W    = 8,
  parameter int NDR  = 4,
  localparam int DRW = $clog2(NDR)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    boot_i,
  input  logic                    wcr_we_i,
  input  logic [W-1:0]            wcr_d_i,
  input  logic                    step_i,
  input  logic                    step_up_i,
  input  logic                    dr_we_i,
  input  logic [DRW-1:0]          dr_sel_i,
  input  logic [W-1:0]            dr_d_i,
  output logic [W-1:0]            wcr_o,
  output logic [NDR-1:0][W-1:0]   dr_o
);
  logic [W-1:0]          wcr_q;
  logic [NDR-1:0][W-1:0] dr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wcr_q <= '0;
    else if (boot_i)     wcr_q <= dr_q[0];
    else if (wcr_we_i)   wcr_q <= wcr_d_i;
    else if (step_i) begin
      if (step_up_i && wcr_q != '1)       wcr_q <= wcr_q + W'(1);
      else if (!step_up_i && wcr_q != '0) wcr_q <= wcr_q - W'(1);
    end
  end

  // storage array models non-volatile cells: no reset
  always_ff @(posedge clk_i) begin
    if (dr_we_i) dr_q[dr_sel_i] <= dr_d_i;
  end

  assign wcr_o = wcr_q;
  assign dr_o  = dr_q;

  assert_step_ceiling_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && step_up_i && !boot_i && !wcr_we_i && wcr_q == '1) |=> (wcr_q == '1));
  assert_step_floor_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !step_up_i && !boot_i && !wcr_we_i && wcr_q == '0) |=> (wcr_q == '0));
endmodule

// File: rtl/pot_reg_ctrl.sv
module pot_reg_ctrl
  import pot_ctrl_pkg::*;
#(
  parameter int NCH          = 4,
  parameter int NDR          = 4,
  parameter int W            = 8,
  parameter int WRITE_CYCLES = 500000,
  localparam int CHW = $clog2(NCH),
  localparam int DRW = $clog2(NDR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wp_ni,
  input  logic             cmd_valid_i,
  input  logic [3:0]       cmd_op_i,
  input  logic [CHW-1:0]   cmd_ch_i,
  input  logic [DRW-1:0]   cmd_dr_i,
  input  logic [W-1:0]     cmd_data_i,
  output logic             rd_valid_o,
  output logic [W-1:0]     rd_data_o,
  output logic             wip_o,
  output logic [NCH*W-1:0] wcr_o
);
  logic                  boot_q;
  logic                  acc, is_read, is_drmod, dr_ok, nv_start;
  pot_op_e               op;
  logic [W-1:0]          ch_wcr [NCH];
  logic [NDR-1:0][W-1:0] ch_dr  [NCH];
  logic [W-1:0]          sel_wcr, sel_dr, rd_d;
  logic                  rd_valid_q;
  logic [W-1:0]          rd_data_q;

  assign op       = pot_op_e'(cmd_op_i);
  assign acc      = cmd_valid_i && !boot_q;
  assign is_read  = (op == OP_RD_WCR) || (op == OP_RD_DR) || (op == OP_RD_STAT);
  assign is_drmod = (op == OP_WR_DR) || (op == OP_WCR2DR);
  assign dr_ok    = acc && is_drmod && wp_ni && !wip_o;
  assign nv_start = dr_ok;
  assign sel_wcr  = ch_wcr[cmd_ch_i];
  assign sel_dr   = ch_dr[cmd_ch_i][cmd_dr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) boot_q <= 1'b1;
    else         boot_q <= 1'b0;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = acc && (cmd_ch_i == CHW'(c));
    wiper_chan #(.W(W), .NDR(NDR)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .boot_i    (boot_q),
      .wcr_we_i  (hit && (op == OP_WR_WCR || op == OP_DR2WCR)),
      .wcr_d_i   ((op == OP_WR_WCR) ? cmd_data_i : sel_dr),
      .step_i    (hit && op == OP_STEP),
      .step_up_i (cmd_data_i[0]),
      .dr_we_i   (dr_ok && (cmd_ch_i == CHW'(c))),
      .dr_sel_i  (cmd_dr_i),
      .dr_d_i    ((op == OP_WR_DR) ? cmd_data_i : ch_wcr[c]),
      .wcr_o     (ch_wcr[c]),
      .dr_o      (ch_dr[c])
    );
    assign wcr_o[c*W +: W] = ch_wcr[c];
  end

  nv_busy_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (nv_start),
    .busy_o  (wip_o)
  );

  always_comb begin
    case (op)
      OP_RD_WCR: rd_d = sel_wcr;
      OP_RD_DR:  rd_d = sel_dr;
      default:   rd_d = {{(W-1){1'b0}}, wip_o};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= acc && is_read;
      if (acc && is_read) rd_data_q <= rd_d;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  assert_read_resp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !boot_q && is_read) |=> rd_valid_o);
  assert_protect_no_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !wp_ni && !wip_o) |=> !wip_o);
  assert_no_read_on_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !rd_valid_o);
endmodule

// File: tb/pot_reg_ctrl_bench.sv
module pot_reg_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCYC = 5;

  localparam logic [3:0] C_STEP = 4'h2, C_STAT = 4'h5, C_RWCR = 4'h9, C_WWCR = 4'hA,
                         C_RDR = 4'hB, C_WDR = 4'hC, C_LD = 4'hD, C_ST = 4'hE;

  logic clk = 0, rst_ni = 0, wp_ni = 1, cmd_valid_i = 0;
  logic [3:0] cmd_op_i = 0;
  logic [1:0] cmd_ch_i = 0, cmd_dr_i = 0;
  logic [7:0] cmd_data_i = 0;
  logic rd_valid_o, wip_o;
  logic [7:0] rd_data_o;
  logic [31:0] wcr_o;

  pot_reg_ctrl #(.WRITE_CYCLES(NCYC)) u_pot_reg_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .wp_ni(wp_ni), .cmd_valid_i(cmd_valid_i),
    .cmd_op_i(cmd_op_i), .cmd_ch_i(cmd_ch_i), .cmd_dr_i(cmd_dr_i),
    .cmd_data_i(cmd_data_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .wip_o(wip_o), .wcr_o(wcr_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  string tag = "R1";

  logic [7:0] wcr_m [4];
  logic [7:0] dr_m [4][4];
  int cnt_m = 0;
  bit boot_m = 0, wcr_known = 0;
  bit rdv_m = 0;
  logic [7:0] rdd_m = 0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("rd_valid", rd_valid_o, rdv_m);
    if (rdv_m) chk("rd_data", rd_data_o, rdd_m);
    chk("wip", wip_o, cnt_m != 0);
    if (wcr_known)
      for (int c = 0; c < 4; c++) chk($sformatf("wcr%0d", c), wcr_o[c*8 +: 8], wcr_m[c]);
  endtask

  task automatic cyc(bit v, logic [3:0] op, int ch, int ds, logic [7:0] d);
    bit wip_now, start;
    cmd_valid_i = v; cmd_op_i = op; cmd_ch_i = ch[1:0]; cmd_dr_i = ds[1:0]; cmd_data_i = d;
    rdv_m = 0; start = 0;
    if (boot_m) begin
      for (int c = 0; c < 4; c++) wcr_m[c] = dr_m[c][0];
      boot_m = 0;
    end else begin
      wip_now = (cnt_m != 0);
      if (v) case (op)
        C_RWCR: begin rdv_m = 1; rdd_m = wcr_m[ch]; end
        C_WWCR: wcr_m[ch] = d;
        C_RDR:  begin rdv_m = 1; rdd_m = dr_m[ch][ds]; end
        C_WDR:  if (wp_ni && !wip_now) begin dr_m[ch][ds] = d; start = 1; end
        C_LD:   wcr_m[ch] = dr_m[ch][ds];
        C_ST:   if (wp_ni && !wip_now) begin dr_m[ch][ds] = wcr_m[ch]; start = 1; end
        C_STEP: if (d[0]) begin if (wcr_m[ch] != 8'hFF) wcr_m[ch]++; end
                else begin if (wcr_m[ch] != 8'h00) wcr_m[ch]--; end
        C_STAT: begin rdv_m = 1; rdd_m = {7'b0, wip_now}; end
        default: ;
      endcase
    end
    if (start) cnt_m = NCYC; else if (cnt_m > 0) cnt_m--;
    @(posedge clk); @(negedge clk);
    compare();
  endtask

  task automatic idle_until_free();
    while (cnt_m != 0) cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst_ni = 0; cmd_valid_i = 0;
    cnt_m = 0; rdv_m = 0;
    repeat (2) @(negedge clk);
    tag = "R1";
    chk("wip in reset", wip_o, 0);
    chk("rd_valid in reset", rd_valid_o, 0);
    rst_ni = 1; boot_m = 1; wcr_known = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset(); wcr_known = 0;
    cyc(0, 0, 0, 0, 0);
    // R3, R8: fill every data register, waiting out each write cycle
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        tag = "R3"; cyc(1, C_WDR, c, r, 8'(16*c + r + 8'h21));
        tag = "R8"; idle_until_free();
      end
    tag = "R7";
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) cyc(1, C_RDR, c, r, 0);
    // R1, R11: reset boots wipers from DR0, data registers survive
    do_reset();
    tag = "R1"; cyc(1, C_WWCR, 0, 0, 8'h77); // boot cycle: command ignored
    tag = "R11"; for (int c = 0; c < 4; c++) cyc(1, C_RDR, c, 3, 0);
    tag = "R7"; cyc(1, C_RWCR, 2, 0, 0);
    // R2
    tag = "R2"; cyc(1, C_WWCR, 2, 0, 8'h40); cyc(1, C_WWCR, 1, 0, 8'hFE);
    cyc(1, C_WWCR, 3, 0, 8'h01);
    // R6 saturation
    tag = "R6"; cyc(1, C_STEP, 1, 0, 8'h01); cyc(1, C_STEP, 1, 0, 8'h01); cyc(1, C_STEP, 1, 0, 8'h01);
    cyc(1, C_STEP, 3, 0, 8'h00); cyc(1, C_STEP, 3, 0, 8'h00); cyc(1, C_STEP, 2, 0, 8'h00);
    // R4
    tag = "R4"; cyc(1, C_LD, 1, 2, 0); cyc(1, C_LD, 0, 3, 0);
    // R5
    tag = "R5"; cyc(1, C_ST, 3, 1, 0);
    tag = "R10"; cyc(1, C_WDR, 0, 0, 8'hAA); cyc(1, C_ST, 2, 2, 0);
    tag = "R7"; cyc(1, C_STAT, 0, 0, 0);
    tag = "R8"; idle_until_free();
    tag = "R5"; cyc(1, C_RDR, 3, 1, 0); cyc(1, C_RDR, 0, 0, 0);
    tag = "R7"; cyc(1, C_STAT, 0, 0, 0);
    // R9: protect blocks data changes only
    wp_ni = 0; tag = "R9";
    cyc(1, C_WDR, 1, 1, 8'h5C); cyc(1, C_ST, 2, 0, 0); cyc(1, C_WWCR, 0, 0, 8'h99);
    cyc(1, C_RDR, 1, 1, 0); cyc(1, C_RDR, 2, 0, 0);
    wp_ni = 1;
    cyc(1, C_WDR, 1, 1, 8'h5C); idle_until_free(); cyc(1, C_RDR, 1, 1, 0);
    // R12: unused codes
    tag = "R12"; cyc(1, 4'hF, 0, 0, 8'h12); cyc(1, 4'h0, 1, 0, 8'h34); cyc(1, 4'h7, 2, 1, 8'h56);
    cyc(1, C_RDR, 0, 0, 0);
    finish_run();
  end
endmodule